// File: doc/BRIEF.md
# Data Cache Store and Flush Queue

This block is the write-side control of a small data cache. Stores from the core pipeline enter a three-entry buffer. The core is stalled only once all three entries are occupied. Each store carries a storage-attribute bit that selects write-through or write-back handling. The buffer drains one store per cycle, oldest first, while the tag/data array port is free.

Loads can look into the buffer. A load whose word address matches a buffered store returns the newest matching data. The core therefore never reads a stale value from the array while that store is still waiting.

Dirty-line evictions are handed to a two-entry flush queue. Each queued line goes to memory as eight consecutive word beats. Single-word store writes use the same memory write port. When the last beat of a line is accepted, the block tells the array to clear that line's dirty bit.

Top module: `dcWriteCtl`

## Requirements
- R1: The store buffer holds at most three stores. `stall` is high exactly when three are held. A store presented while `stall` is high is not taken and never reaches the array, the memory port or load forwarding.
- R2: Buffered stores leave in the order they were accepted, at most one per cycle. No store leaves and `arrWrEn` stays low in any cycle with `arrBusy` high.
- R3: A draining store with attribute `stWt`=1 that hits (`arrHit`=1) writes the array (`arrWrEn`=1, `arrSetDirty`=0). In the same cycle it offers one memory word write with the store's address and data.
- R4: A draining store with `stWt`=0 that hits writes the array with `arrSetDirty`=1 and makes no memory write.
- R5: A draining store that misses (`arrHit`=0) makes no array write, under either attribute. It is sent to memory as a single word write.
- R6: With `ldReq` high, `ldFwdHit` is high when any buffered store has word address `ldAddr`. `ldFwdData` is then the data of the most recently accepted such store.
- R7: The flush queue holds at most two lines. `evictFull` is high when two are held. `evictAck` equals `evictReq` while not full. An eviction presented while full is not queued and never produces memory beats.
- R8: A queued line is sent as eight beats with memory word address {line, beat} for beats 0 to 7 in ascending order. `memWrLast` is high on beat 7. `arrClrDirty` pulses with `arrClrLine` equal to the line in the cycle that beat 7 is accepted.
- R9: Once a line's first beat has been offered, the burst keeps the memory port until beat 7 is accepted. Between bursts, a store waiting for a memory write is served before a new line starts.
- R10: A flush beat offered while `memWrReady` is low stays offered in the next cycle with unchanged address and data.
- R11: After reset both queues are empty. `stall`, `evictFull`, `memWrValid`, `arrWrEn` and `ldFwdHit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stReq | input | 1 | Store request from core |
| stAddr | input | 12 | Store word address |
| stData | input | 32 | Store data |
| stWt | input | 1 | Storage attribute: 1 write-through, 0 write-back |
| stall | output | 1 | Store buffer full, core must hold |
| ldReq | input | 1 | Load probe valid |
| ldAddr | input | 12 | Load word address |
| ldFwdHit | output | 1 | Load matches a buffered store |
| ldFwdData | output | 32 | Newest matching buffered data |
| arrBusy | input | 1 | Array port unavailable this cycle |
| arrHit | input | 1 | Lookup result for `arrAddr` |
| arrAddr | output | 12 | Lookup and write address (oldest store) |
| arrWrEn | output | 1 | Array word write |
| arrWrData | output | 32 | Array write data |
| arrSetDirty | output | 1 | Mark written line dirty |
| arrClrDirty | output | 1 | Clear dirty bit of `arrClrLine` |
| arrClrLine | output | 9 | Line address whose flush completed |
| evictReq | input | 1 | Dirty line eviction request |
| evictLine | input | 9 | Evicted line address |
| evictData | input | 256 | Eight words of the line, word 0 in the low bits |
| evictAck | output | 1 | Eviction accepted into queue |
| evictFull | output | 1 | Flush queue full |
| memWrValid | output | 1 | Memory write beat offered |
| memWrReady | input | 1 | Memory accepts the beat |
| memWrAddr | output | 12 | Memory word address |
| memWrData | output | 32 | Memory write data |
| memWrLast | output | 1 | Final beat of a line flush |

## Verification
The bench fills the buffer while the array is busy and offers a fourth store. A design that counted wrongly would either drop a good store or let the fourth one leak into forwarding and the array writes. Forwarding is probed with two stores to the same address, so a design that picks the oldest match returns the superseded data. Flush beats are held back by memory and then released, which exposes an address that wanders under backpressure or a dirty clear on the wrong beat. A write-through store is made to arrive in the middle of a burst. If the burst is split, a flush word is replaced by the store word. If the priority is wrong between bursts, the next line starts before the waiting store.

// File: rtl/dcwPkg.sv
package dcwPkg;
  typedef struct packed {
    logic sbPush;
    logic sbPop;
    logic fqPush;
    logic fqPop;
    logic selFlush;
  } dcwStrobes_t;
endpackage

// File: rtl/dcwDatapath.sv
module dcwDatapath
  import dcwPkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int SB_DEPTH = 3,
  parameter int FQ_DEPTH = 2,
  parameter int LINE_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dcwStrobes_t              strb,
  input  logic [$clog2(LINE_WORDS)-1:0] wordIdx,
  input  logic [AW-1:0]            stAddr,
  input  logic [DW-1:0]            stData,
  input  logic                     stWt,
  input  logic                     ldReq,
  input  logic [AW-1:0]            ldAddr,
  output logic                     ldFwdHit,
  output logic [DW-1:0]            ldFwdData,
  input  logic [AW-$clog2(LINE_WORDS)-1:0] evictLine,
  input  logic [LINE_WORDS*DW-1:0] evictData,
  output logic                     sbFull,
  output logic                     sbHeadValid,
  output logic                     headWt,
  output logic [AW-1:0]            headAddr,
  output logic [DW-1:0]            headData,
  output logic                     fqFull,
  output logic                     fqHeadValid,
  output logic [AW-$clog2(LINE_WORDS)-1:0] fqHeadLine,
  output logic [AW-1:0]            memWrAddr,
  output logic [DW-1:0]            memWrData
);
  localparam int LWB = $clog2(LINE_WORDS);
  localparam int LAW = AW - LWB;
  localparam int SBP = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;
  localparam int FQP = (FQ_DEPTH > 1) ? $clog2(FQ_DEPTH) : 1;

  logic [AW-1:0]            sbAddr [SB_DEPTH];
  logic [DW-1:0]            sbData [SB_DEPTH];
  logic [SB_DEPTH-1:0]      sbWtBits;
  logic [SB_DEPTH-1:0]      sbVld;
  logic [SBP-1:0]           sbWr, sbRd;

  logic [LAW-1:0]           fqLine  [FQ_DEPTH];
  logic [LINE_WORDS*DW-1:0] fqWords [FQ_DEPTH];
  logic [FQ_DEPTH-1:0]      fqVld;
  logic [FQP-1:0]           fqWr, fqRd;

  function automatic logic [SBP-1:0] sbNext(input logic [SBP-1:0] p);
    return (p == SBP'(SB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [FQP-1:0] fqNext(input logic [FQP-1:0] p);
    return (p == FQP'(FQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // store buffer occupancy and pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sbVld <= '0;
      sbWr  <= '0;
      sbRd  <= '0;
    end else begin
      if (strb.sbPush) begin
        sbVld[sbWr] <= 1'b1;
        sbWr        <= sbNext(sbWr);
      end
      if (strb.sbPop) begin
        sbVld[sbRd] <= 1'b0;
        sbRd        <= sbNext(sbRd);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.sbPush) begin
      sbAddr[sbWr]   <= stAddr;
      sbData[sbWr]   <= stData;
      sbWtBits[sbWr] <= stWt;
    end
  end

  // flush queue occupancy and pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fqVld <= '0;
      fqWr  <= '0;
      fqRd  <= '0;
    end else begin
      if (strb.fqPush) begin
        fqVld[fqWr] <= 1'b1;
        fqWr        <= fqNext(fqWr);
      end
      if (strb.fqPop) begin
        fqVld[fqRd] <= 1'b0;
        fqRd        <= fqNext(fqRd);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fqPush) begin
      fqLine[fqWr]  <= evictLine;
      fqWords[fqWr] <= evictData;
    end
  end

  assign sbFull      = &sbVld;
  assign sbHeadValid = sbVld[sbRd];
  assign headWt      = sbWtBits[sbRd];
  assign headAddr    = sbAddr[sbRd];
  assign headData    = sbData[sbRd];
  assign fqFull      = &fqVld;
  assign fqHeadValid = fqVld[fqRd];
  assign fqHeadLine  = fqLine[fqRd];

  // forwarding: walk from oldest to newest, the last match wins
  always_comb begin
    logic [SBP:0]   sum;
    logic [SBP-1:0] idx;
    ldFwdHit  = 1'b0;
    ldFwdData = '0;
    for (int i = 0; i < SB_DEPTH; i++) begin
      sum = {1'b0, sbRd} + (SBP + 1)'(i);
      idx = (sum >= (SBP + 1)'(SB_DEPTH)) ? SBP'(sum - (SBP + 1)'(SB_DEPTH)) : SBP'(sum);
      if (ldReq && sbVld[idx] && (sbAddr[idx] == ldAddr)) begin
        ldFwdHit  = 1'b1;
        ldFwdData = sbData[idx];
      end
    end
  end

  // memory port mux between the flush beat and the oldest store
  always_comb begin
    if (strb.selFlush) begin
      memWrAddr = {fqLine[fqRd], wordIdx};
      memWrData = fqWords[fqRd][wordIdx * DW +: DW];
    end else begin
      memWrAddr = sbAddr[sbRd];
      memWrData = sbData[sbRd];
    end
  end

  assert_sb_no_overwrite_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.sbPush |-> !sbVld[sbWr]);
  assert_sb_pop_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sbPop |-> sbVld[sbRd]);
  assert_fq_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.fqPush |-> !fqVld[fqWr]);
endmodule

// File: rtl/dcwControl.sv
module dcwControl
  import dcwPkg::*;
#(
  parameter int LINE_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stReq,
  input  logic        evictReq,
  input  logic        arrBusy,
  input  logic        arrHit,
  input  logic        memWrReady,
  input  logic        sbFull,
  input  logic        sbHeadValid,
  input  logic        headWt,
  input  logic        fqFull,
  input  logic        fqHeadValid,
  output dcwStrobes_t strb,
  output logic [$clog2(LINE_WORDS)-1:0] wordIdx,
  output logic        stall,
  output logic        evictAck,
  output logic        arrWrEn,
  output logic        arrSetDirty,
  output logic        arrClrDirty,
  output logic        memWrValid,
  output logic        memWrLast
);
  localparam int LWB = $clog2(LINE_WORDS);

  logic burstLock;
  logic storeNeedsMem, storeWantsMem, flushOwns, storeMemOk;
  logic flushBeat, lastBeat;

  assign stall    = sbFull;
  assign evictAck = evictReq && !fqFull;

  assign storeNeedsMem = headWt || !arrHit;
  assign storeWantsMem = sbHeadValid && storeNeedsMem && !arrBusy;
  // a started burst keeps the port; otherwise a waiting store goes first
  assign flushOwns     = fqHeadValid && (burstLock || !storeWantsMem);
  assign storeMemOk    = storeNeedsMem ? (!flushOwns && memWrReady) : 1'b1;

  assign memWrValid = flushOwns || storeWantsMem;
  assign memWrLast  = flushOwns && (wordIdx == LWB'(LINE_WORDS - 1));
  assign flushBeat  = flushOwns && memWrReady;
  assign lastBeat   = flushBeat && memWrLast;

  always_comb begin
    strb          = '0;
    strb.sbPush   = stReq && !sbFull;
    strb.sbPop    = sbHeadValid && !arrBusy && storeMemOk;
    strb.fqPush   = evictAck;
    strb.fqPop    = lastBeat;
    strb.selFlush = flushOwns;
  end

  assign arrWrEn     = strb.sbPop && arrHit;
  assign arrSetDirty = arrWrEn && !headWt;
  assign arrClrDirty = lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx   <= '0;
      burstLock <= 1'b0;
    end else begin
      if (lastBeat)       wordIdx <= '0;
      else if (flushBeat) wordIdx <= wordIdx + 1'b1;
      burstLock <= flushOwns && !lastBeat;
    end
  end

  assert_array_quiet_when_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    arrBusy |-> !arrWrEn);
  assert_burst_keeps_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flushOwns && !lastBeat) |=> flushOwns);
endmodule

// File: rtl/dcWriteCtl.sv
module dcWriteCtl
  import dcwPkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int SB_DEPTH = 3,
  parameter int FQ_DEPTH = 2,
  parameter int LINE_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stReq,
  input  logic [AW-1:0]            stAddr,
  input  logic [DW-1:0]            stData,
  input  logic                     stWt,
  output logic                     stall,
  input  logic                     ldReq,
  input  logic [AW-1:0]            ldAddr,
  output logic                     ldFwdHit,
  output logic [DW-1:0]            ldFwdData,
  input  logic                     arrBusy,
  input  logic                     arrHit,
  output logic [AW-1:0]            arrAddr,
  output logic                     arrWrEn,
  output logic [DW-1:0]            arrWrData,
  output logic                     arrSetDirty,
  output logic                     arrClrDirty,
  output logic [AW-$clog2(LINE_WORDS)-1:0] arrClrLine,
  input  logic                     evictReq,
  input  logic [AW-$clog2(LINE_WORDS)-1:0] evictLine,
  input  logic [LINE_WORDS*DW-1:0] evictData,
  output logic                     evictAck,
  output logic                     evictFull,
  output logic                     memWrValid,
  input  logic                     memWrReady,
  output logic [AW-1:0]            memWrAddr,
  output logic [DW-1:0]            memWrData,
  output logic                     memWrLast
);
  localparam int LWB = $clog2(LINE_WORDS);

  dcwStrobes_t    strb;
  logic [LWB-1:0] wordIdx;
  logic sbFull, sbHeadValid, headWt, fqHeadValid;

  dcwDatapath #(
    .AW(AW), .DW(DW), .SB_DEPTH(SB_DEPTH), .FQ_DEPTH(FQ_DEPTH), .LINE_WORDS(LINE_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx),
    .stAddr(stAddr), .stData(stData), .stWt(stWt),
    .ldReq(ldReq), .ldAddr(ldAddr), .ldFwdHit(ldFwdHit), .ldFwdData(ldFwdData),
    .evictLine(evictLine), .evictData(evictData),
    .sbFull(sbFull), .sbHeadValid(sbHeadValid), .headWt(headWt),
    .headAddr(arrAddr), .headData(arrWrData),
    .fqFull(evictFull), .fqHeadValid(fqHeadValid), .fqHeadLine(arrClrLine),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  dcwControl #(.LINE_WORDS(LINE_WORDS)) uCtl (
    .clk(clk), .rstN(rstN), .stReq(stReq), .evictReq(evictReq),
    .arrBusy(arrBusy), .arrHit(arrHit), .memWrReady(memWrReady),
    .sbFull(sbFull), .sbHeadValid(sbHeadValid), .headWt(headWt),
    .fqFull(evictFull), .fqHeadValid(fqHeadValid),
    .strb(strb), .wordIdx(wordIdx), .stall(stall), .evictAck(evictAck),
    .arrWrEn(arrWrEn), .arrSetDirty(arrSetDirty), .arrClrDirty(arrClrDirty),
    .memWrValid(memWrValid), .memWrLast(memWrLast)
  );

  assert_flush_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && strb.selFlush && !memWrReady)
      |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData)));
  assert_clear_on_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    arrClrDirty |-> (memWrValid && memWrReady && memWrLast));
  assert_dirty_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrSetDirty |-> (arrWrEn && !arrBusy));
endmodule

// File: tb/tb_dcWriteCtl.sv
`timescale 1ns/1ps
module tb_dcWriteCtl;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int LAW = AW - 3;
  localparam int VW = AW + DW + 5;
  localparam int NV = 8;

  // {addr, data, wt, hit, expArrWr, expDirty, expMem}
  localparam logic [VW-1:0] VECS [NV] = '{
    {12'h010, 32'hA5A50001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {12'h011, 32'hA5A50002, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {12'h020, 32'hA5A50003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {12'h021, 32'hA5A50004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {12'hFFF, 32'hFFFF0005, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {12'h000, 32'h00000006, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {12'h7FF, 32'h12340007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {12'h800, 32'h80000008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic stReq = 0, stWt = 0, ldReq = 0, arrBusy = 0, arrHit = 0;
  logic evictReq = 0, memWrReady = 0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [LAW-1:0] evictLine = '0;
  logic [LW*DW-1:0] evictData = '0;
  logic stall, ldFwdHit, arrWrEn, arrSetDirty, arrClrDirty, evictAck, evictFull;
  logic memWrValid, memWrLast;
  logic [DW-1:0] ldFwdData, arrWrData, memWrData;
  logic [AW-1:0] arrAddr, memWrAddr;
  logic [LAW-1:0] arrClrLine;

  int nVec = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dcWriteCtl dut (
    .clk(clk), .rstN(rstN), .stReq(stReq), .stAddr(stAddr), .stData(stData), .stWt(stWt),
    .stall(stall), .ldReq(ldReq), .ldAddr(ldAddr), .ldFwdHit(ldFwdHit), .ldFwdData(ldFwdData),
    .arrBusy(arrBusy), .arrHit(arrHit), .arrAddr(arrAddr), .arrWrEn(arrWrEn),
    .arrWrData(arrWrData), .arrSetDirty(arrSetDirty), .arrClrDirty(arrClrDirty),
    .arrClrLine(arrClrLine), .evictReq(evictReq), .evictLine(evictLine),
    .evictData(evictData), .evictAck(evictAck), .evictFull(evictFull),
    .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrLast(memWrLast)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fw(input logic [LAW-1:0] ln, input int k);
    return 32'hF0000000 | (32'(ln) << 8) | 32'(k);
  endfunction

  task automatic pushEvict(input logic [LAW-1:0] ln);
    evictReq  = 1;
    evictLine = ln;
    for (int k = 0; k < LW; k++) evictData[k*DW +: DW] = fw(ln, k);
  endtask

  task automatic pushStore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic wt);
    stReq = 1; stAddr = a; stData = d; stWt = wt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    #1 chk("R11 stall in reset", 64'(stall), 0);
    rstN = 1;
    #1;
    chk("R11 stall", 64'(stall), 0);
    chk("R11 memWrValid", 64'(memWrValid), 0);
    chk("R11 evictFull", 64'(evictFull), 0);
    chk("R11 arrWrEn", 64'(arrWrEn), 0);
    ldReq = 1; ldAddr = 12'h000;
    #1 chk("R11 ldFwdHit", 64'(ldFwdHit), 0);
    ldReq = 0;

    // table walk: R3 R4 R5 per store attribute and hit
    memWrReady = 1;
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a; logic [DW-1:0] d;
      logic wt, hit, eA, eD, eM;
      {a, d, wt, hit, eA, eD, eM} = VECS[v];
      @(negedge clk);
      pushStore(a, d, wt); arrHit = hit;
      @(negedge clk);
      stReq = 0;
      #1;
      chk(hit ? (wt ? "R3 arrWrEn" : "R4 arrWrEn") : "R5 arrWrEn", 64'(arrWrEn), 64'(eA));
      chk(wt ? "R3 arrSetDirty" : "R4 arrSetDirty", 64'(arrSetDirty), 64'(eD));
      chk(eM ? "R3/R5 memWrValid" : "R4 memWrValid", 64'(memWrValid), 64'(eM));
      if (eA) chk("R3 arrWrData", 64'(arrWrData), 64'(d));
      if (eM) begin
        chk("R5 memWrAddr", 64'(memWrAddr), 64'(a));
        chk("R5 memWrData", 64'(memWrData), 64'(d));
      end
      @(negedge clk);
      #1 chk("R2 drained once", 64'({memWrValid, arrWrEn}), 0);
    end

    // R1 / R6 / R2: fill while array busy
    @(negedge clk);
    arrBusy = 1; arrHit = 1;
    pushStore(12'h0A0, 32'h11111111, 0);
    @(negedge clk) pushStore(12'h0B0, 32'h22222222, 0);
    #1 chk("R1 stall after one", 64'(stall), 0);
    @(negedge clk) pushStore(12'h0A0, 32'h33333333, 0);
    #1 chk("R1 stall after two", 64'(stall), 0);
    @(negedge clk) pushStore(12'h0C0, 32'h44444444, 0);
    #1 chk("R1 stall at three", 64'(stall), 1);
    @(negedge clk) stReq = 0;
    #1;
    chk("R1 stall holds", 64'(stall), 1);
    chk("R2 no write while busy", 64'(arrWrEn), 0);
    ldReq = 1; ldAddr = 12'h0A0;
    #1 chk("R6 newest match", 64'({ldFwdHit, ldFwdData}), {31'd0, 1'b1, 32'h33333333});
    ldAddr = 12'h0B0;
    #1 chk("R6 single match", 64'({ldFwdHit, ldFwdData}), {31'd0, 1'b1, 32'h22222222});
    ldAddr = 12'h0C0;
    #1 chk("R1 rejected store not forwarded", 64'(ldFwdHit), 0);
    ldReq = 0;
    arrBusy = 0;
    #1 chk("R2 first out", 64'({arrWrEn, arrAddr, arrWrData}), {19'd0, 1'b1, 12'h0A0, 32'h11111111});
    @(negedge clk);
    #1 chk("R2 second out", 64'({arrWrEn, arrAddr, arrWrData}), {19'd0, 1'b1, 12'h0B0, 32'h22222222});
    chk("R1 stall released", 64'(stall), 0);
    @(negedge clk);
    #1 chk("R2 third out", 64'({arrWrEn, arrAddr, arrWrData}), {19'd0, 1'b1, 12'h0A0, 32'h33333333});
    @(negedge clk);
    #1 chk("R1 fourth never written", 64'(arrWrEn), 0);

    // R7 / R10 / R8: flush queue
    memWrReady = 0;
    @(negedge clk) pushEvict(9'h041);
    #1 chk("R7 ack first", 64'(evictAck), 1);
    @(negedge clk) pushEvict(9'h042);
    #1 chk("R7 ack second", 64'(evictAck), 1);
    @(negedge clk) pushEvict(9'h043);
    #1 chk("R7 full", 64'({evictFull, evictAck}), 64'b10);
    @(negedge clk) evictReq = 0;
    #1 chk("R10 offered", 64'({memWrValid, memWrAddr}), {51'd0, 1'b1, 9'h041, 3'd0});
    @(negedge clk);
    #1 chk("R10 held", 64'({memWrValid, memWrAddr, memWrData}), {19'd0, 1'b1, 9'h041, 3'd0, fw(9'h041, 0)});
    memWrReady = 1;
    for (int n = 0; n < 2; n++) begin
      logic [LAW-1:0] ln;
      ln = (n == 0) ? 9'h041 : 9'h042;
      for (int k = 0; k < LW; k++) begin
        #1;
        chk("R8 beat addr", 64'(memWrAddr), 64'({ln, 3'(k)}));
        chk("R8 beat data", 64'(memWrData), 64'(fw(ln, k)));
        chk("R8 last/clear", 64'({memWrLast, arrClrDirty}), (k == LW - 1) ? 64'b11 : 64'b00);
        if (k == LW - 1) chk("R8 clear line", 64'(arrClrLine), 64'(ln));
        @(negedge clk);
      end
    end
    #1 chk("R7 third line never sent", 64'({memWrValid, evictFull}), 0);

    // R9: store arrives mid-burst
    memWrReady = 0;
    @(negedge clk) pushEvict(9'h051);
    @(negedge clk) pushEvict(9'h052);
    @(negedge clk) evictReq = 0; memWrReady = 1;
    #1 chk("R9 burst start", 64'(memWrAddr), 64'({9'h051, 3'd0}));
    @(negedge clk);
    #1 chk("R9 beat one", 64'(memWrAddr), 64'({9'h051, 3'd1}));
    pushStore(12'h123, 32'hCAFE0123, 1); arrHit = 1;
    @(negedge clk) stReq = 0;
    for (int k = 2; k < LW; k++) begin
      #1;
      chk("R9 burst not split", 64'(memWrAddr), 64'({9'h051, 3'(k)}));
      chk("R9 store waits", 64'(arrWrEn), 0);
      @(negedge clk);
    end
    #1;
    chk("R9 store before next line", 64'({memWrAddr, memWrData}), {20'd0, 12'h123, 32'hCAFE0123});
    chk("R3 mid-flush store array write", 64'(arrWrEn), 1);
    @(negedge clk);
    for (int k = 0; k < LW; k++) begin
      #1 chk("R8 second line beat", 64'(memWrAddr), 64'({9'h052, 3'(k)}));
      @(negedge clk);
    end
    #1 chk("R8 queue drained", 64'(memWrValid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule